// File: doc/BRIEF.md
# Extended I/O Machine-Control Register Bank

This block sits on the I/O side of an 8-bit CPU with a 16-bit port address and active-low I/O request, read and write strobes. It claims every port whose low twelve address bits equal `E3B` hex. The remaining top four address bits pick one of sixteen slots. Five of those slots are readable and writable 8-bit registers: hardware control, screen mode, border colour, the 16K page placed at 8000h and the 16K page placed at C000h. Two slots are write-only palette ports that emit a one-clock strobe with the written byte. All other slots are unused.

The register values are driven out continuously to the rest of the machine. The palette strobes feed a palette store that lies outside this block. A CPU write is recognised once, on the first clock in which I/O request and write are both low, however long the CPU holds them. A read puts the selected register on the data-out bus, with an enable, only while I/O request and read are both low.

Top module: `xio_regbank`

## Requirements
- R1: An access is decoded only when `io_addr[11:0]` equals 12'hE3B. Any other address changes no register, raises no strobe and does not assert `io_rdata_oe`.
- R2: A write to top nibble 0, 1, 4, 6 or 7 stores all 8 data bits into hardware control, screen mode, border, page-at-8000h or page-at-C000h respectively. The new value is visible on the output the clock after the write begins.
- R3: While `rst_n` is low at a clock edge, all registers clear to 8'h00 except the border, which becomes 8'h07. Both palette strobes clear to 0.
- R4: A write to nibble B pulses `pal_idx_stb`, and a write to nibble F pulses `pal_rgb_stb`. The pulse is one clock long, starts the clock after the write begins, and `pal_data` carries the written byte while it is high. The two strobes are never high together.
- R5: A write to an unassigned nibble (2, 3, 5, 8, 9, A, C, D, E) changes no register and raises no strobe. A read of such a nibble gives `io_rdata` = 8'hFF with `io_rdata_oe` low.
- R6: `io_rdata_oe` is high only while `iorq_n` and `rd_n` are both low and a readable register is addressed; `io_rdata` then equals that register. Whenever `io_rdata_oe` is low, `io_rdata` is 8'hFF.
- R7: A read of palette nibble B or F gives 8'hFF with `io_rdata_oe` low.
- R8: A write held low for several clocks commits once. A second commit needs `iorq_n` or `wr_n` to go high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | CPU port address |
| io_wdata | input | 8 | CPU write data |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| io_rdata | output | 8 | Read data, 8'hFF when not driving |
| io_rdata_oe | output | 1 | Read data drive enable |
| hw_ctrl | output | 8 | Hardware control register (speed in bits 1:0, paging select) |
| scr_mode | output | 8 | Screen resolution and attribute decode register |
| border_col | output | 8 | Border colour register |
| page_8000 | output | 8 | 16K page mapped at 8000h |
| page_c000 | output | 8 | 16K page mapped at C000h |
| pal_idx_stb | output | 1 | One-clock palette colour-index write strobe |
| pal_rgb_stb | output | 1 | One-clock palette RGB data write strobe |
| pal_data | output | 8 | Byte that goes with a palette strobe |

## Verification
The hardest case to reach is an address that matches in its top nibble but misses by a single bit in the low twelve bits. Random addresses almost never produce one. The stimulus therefore builds many of its addresses from the match pattern and flips one chosen low bit, and it also sends fully random addresses. A second case is a write held for several clocks followed by a re-write at the same port. Directed sequences cover it, and the bench checks for a single strobe and a single commit.

// File: rtl/xio_pkg.sv
// Package: shared slot numbering and reset values for the extended I/O
// register bank. Assumes a 4-bit slot selector taken from the top nibble.
package xio_pkg;

    typedef enum logic [1:0] {
        K_NONE    = 2'd0,
        K_REG     = 2'd1,
        K_PAL_IDX = 2'd2,
        K_PAL_RGB = 2'd3
    } slot_kind_t;

    localparam int unsigned SLOT_HW     = 0;
    localparam int unsigned SLOT_SCR    = 1;
    localparam int unsigned SLOT_BORDER = 4;
    localparam int unsigned SLOT_PG8    = 6;
    localparam int unsigned SLOT_PGC    = 7;
    localparam int unsigned SLOT_PIDX   = 11;
    localparam int unsigned SLOT_PRGB   = 15;

    localparam logic [7:0] BORDER_RST = 8'h07;

    // Classify a slot number into its access kind.
    function automatic slot_kind_t slot_kind(input int unsigned s);
        case (s)
            SLOT_HW, SLOT_SCR, SLOT_BORDER, SLOT_PG8, SLOT_PGC: return K_REG;
            SLOT_PIDX: return K_PAL_IDX;
            SLOT_PRGB: return K_PAL_RGB;
            default:   return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/xio_decode.sv
// Module: address match and write-start detection.
// Assumes the CPU strobes are already synchronous to clk.
module xio_decode #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned MATCH_W = 12,
    parameter logic [MATCH_W-1:0] MATCH_VAL = 12'hE3B,
    localparam int unsigned SEL_W  = ADDR_W - MATCH_W,
    localparam int unsigned NSLOT  = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [NSLOT-1:0]  wr_sel,
    output logic [NSLOT-1:0]  rd_sel
);
    logic             hit;
    logic             wr_act;
    logic             wr_prev;
    logic [SEL_W-1:0] slot;

    // Purpose: form the match and the slot number.
    always_comb begin
        hit  = (io_addr[MATCH_W-1:0] == MATCH_VAL);
        slot = io_addr[ADDR_W-1:MATCH_W];
    end

    // Purpose: remember whether a write cycle was active last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b0;
        else        wr_prev <= wr_act;
    end

    // Purpose: one-hot write and read selects, write only on its first clock.
    always_comb begin
        wr_act = !iorq_n && !wr_n;
        wr_sel = '0;
        rd_sel = '0;
        if (hit && wr_act && !wr_prev) wr_sel[slot] = 1'b1;
        if (hit && !iorq_n && !rd_n)   rd_sel[slot] = 1'b1;
    end
endmodule

// File: rtl/xio_regs.sv
// Module: register storage and palette strobe generation for all slots.
// Assumes wr_sel is one-hot or zero and lasts one clock per CPU write.
module xio_regs
    import xio_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NSLOT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLOT-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] regq [NSLOT],
    output logic              idx_stb,
    output logic              rgb_stb,
    output logic [DATA_W-1:0] stb_data
);
    genvar s;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_slot
            if (slot_kind(s) == K_REG) begin : g_reg
                localparam logic [DATA_W-1:0] RST =
                    (s == SLOT_BORDER) ? DATA_W'(BORDER_RST) : '0;
                // Purpose: hold one control register.
                always_ff @(posedge clk) begin
                    if (!rst_n)         regq[s] <= RST;
                    else if (wr_sel[s]) regq[s] <= wdata;
                end
            end else begin : g_none
                assign regq[s] = '1;
            end
        end
    endgenerate

    // Purpose: register the one-clock palette strobes and their byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_stb  <= 1'b0;
            rgb_stb  <= 1'b0;
            stb_data <= '0;
        end else begin
            idx_stb <= wr_sel[SLOT_PIDX];
            rgb_stb <= wr_sel[SLOT_PRGB];
            if (wr_sel[SLOT_PIDX] || wr_sel[SLOT_PRGB]) stb_data <= wdata;
        end
    end
endmodule

// File: rtl/xio_readmux.sv
// Module: read data selection. Only register slots drive; all else reads FF.
// Assumes rd_sel is one-hot or zero.
module xio_readmux
    import xio_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NSLOT  = 16
) (
    input  logic [NSLOT-1:0]  rd_sel,
    input  logic [DATA_W-1:0] regq [NSLOT],
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    // Purpose: pick the addressed readable register or the idle value.
    always_comb begin
        rdata    = '1;
        rdata_oe = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (rd_sel[i] && slot_kind(i) == K_REG) begin
                rdata    = regq[i];
                rdata_oe = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xio_regbank.sv
// Module: top of the extended I/O machine-control register bank.
// Assumes synchronous CPU strobes; reset is synchronous active-low.
module xio_regbank
    import xio_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned MATCH_W = 12,
    parameter logic [MATCH_W-1:0] MATCH_VAL = 12'hE3B,
    localparam int unsigned NSLOT  = 1 << (ADDR_W - MATCH_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rdata_oe,
    output logic [DATA_W-1:0] hw_ctrl,
    output logic [DATA_W-1:0] scr_mode,
    output logic [DATA_W-1:0] border_col,
    output logic [DATA_W-1:0] page_8000,
    output logic [DATA_W-1:0] page_c000,
    output logic              pal_idx_stb,
    output logic              pal_rgb_stb,
    output logic [DATA_W-1:0] pal_data
);
    logic [NSLOT-1:0]  wr_sel;
    logic [NSLOT-1:0]  rd_sel;
    logic [DATA_W-1:0] regq [NSLOT];

    xio_decode #(.ADDR_W(ADDR_W), .MATCH_W(MATCH_W), .MATCH_VAL(MATCH_VAL)) u_dec (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .wr_sel(wr_sel), .rd_sel(rd_sel)
    );

    xio_regs #(.DATA_W(DATA_W), .NSLOT(NSLOT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(io_wdata),
        .regq(regq), .idx_stb(pal_idx_stb), .rgb_stb(pal_rgb_stb),
        .stb_data(pal_data)
    );

    xio_readmux #(.DATA_W(DATA_W), .NSLOT(NSLOT)) u_rmux (
        .rd_sel(rd_sel), .regq(regq), .rdata(io_rdata), .rdata_oe(io_rdata_oe)
    );

    // Purpose: expose the named registers to the machine.
    always_comb begin
        hw_ctrl    = regq[SLOT_HW];
        scr_mode   = regq[SLOT_SCR];
        border_col = regq[SLOT_BORDER];
        page_8000  = regq[SLOT_PG8];
        page_c000  = regq[SLOT_PGC];
    end
endmodule

// File: rtl/xio_regbank_chk.sv
// Module: assertion checker for xio_regbank, attached by bind.
// Assumes 16-bit addresses with the 12-bit match value E3B.
module xio_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        iorq_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic [7:0]  io_rdata,
    input logic        io_rdata_oe,
    input logic [7:0]  hw_ctrl,
    input logic [7:0]  border_col,
    input logic [7:0]  page_c000,
    input logic        pal_idx_stb,
    input logic        pal_rgb_stb
);
    p_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr[11:0] != 12'hE3B) |=> ($stable(hw_ctrl) && $stable(border_col)
            && $stable(page_c000) && !pal_idx_stb && !pal_rgb_stb));

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iorq_n || wr_n) |=> ($stable(border_col) && $stable(hw_ctrl)));

    p_reset_val_r3: assert property (@(posedge clk)
        !rst_n |=> (border_col == 8'h07 && hw_ctrl == 8'h00 && !pal_idx_stb));

    p_stb_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pal_idx_stb, pal_rgb_stb}));

    p_oe_needs_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_oe |-> (!iorq_n && !rd_n));

    p_idle_ff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rdata_oe |-> (io_rdata == 8'hFF));

    p_single_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_idx_stb || pal_rgb_stb) |=> (!pal_idx_stb && !pal_rgb_stb));
endmodule

bind xio_regbank xio_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
    .hw_ctrl(hw_ctrl), .border_col(border_col), .page_c000(page_c000),
    .pal_idx_stb(pal_idx_stb), .pal_rgb_stb(pal_rgb_stb)
);

// File: tb/xio_regbank_tb_top.sv
// Bench: directed corners plus seeded random traffic against a bench model.
module xio_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  io_rdata, hw_ctrl, scr_mode, border_col, page_8000, page_c000, pal_data;
    logic        io_rdata_oe, pal_idx_stb, pal_rgb_stb;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [16];

    always #5 clk = ~clk;

    xio_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .io_rdata(io_rdata),
        .io_rdata_oe(io_rdata_oe), .hw_ctrl(hw_ctrl), .scr_mode(scr_mode),
        .border_col(border_col), .page_8000(page_8000), .page_c000(page_c000),
        .pal_idx_stb(pal_idx_stb), .pal_rgb_stb(pal_rgb_stb), .pal_data(pal_data)
    );

    function automatic bit is_reg(input int n);
        return (n == 0 || n == 1 || n == 4 || n == 6 || n == 7);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        check({req, " hw"},     hw_ctrl,    model[0]);
        check({req, " scr"},    scr_mode,   model[1]);
        check({req, " border"}, border_col, model[4]);
        check({req, " pg8"},    page_8000,  model[6]);
        check({req, " pgc"},    page_c000,  model[7]);
    endtask

    // Write starting at a negedge, held for hold clocks; checks strobe on the first.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input int hold, input string req);
        bit hit = (a[11:0] == 12'hE3B);
        int n = a[15:12];
        @(negedge clk);
        io_addr = a; io_wdata = d; iorq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        if (hit && is_reg(n)) model[n] = d;
        check({req, " idx_stb"}, pal_idx_stb, hit && n == 11);
        check({req, " rgb_stb"}, pal_rgb_stb, hit && n == 15);
        if (hit && (n == 11 || n == 15)) check({req, " pal_data"}, pal_data, d);
        check_outs(req);
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            check({req, " R8 held no restrobe"}, {pal_idx_stb, pal_rgb_stb}, 2'b00);
        end
        iorq_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic do_read(input logic [15:0] a, input bit use_iorq, input string req);
        bit hit = (a[11:0] == 12'hE3B);
        int n = a[15:12];
        bit drv = use_iorq && hit && is_reg(n);
        @(negedge clk);
        io_addr = a; iorq_n = !use_iorq; rd_n = 1'b0;
        #2;
        check({req, " oe"},    io_rdata_oe, drv);
        check({req, " rdata"}, io_rdata,    drv ? model[n] : 8'hFF);
        iorq_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        model[4] = 8'h07;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R3 reset");
        check("R3 reset idx_stb", pal_idx_stb, 1'b0);
        check("R3 reset oe", io_rdata_oe, 1'b0);

        // Directed corners
        do_write(16'h0E3B, 8'h03, 1, "R2 hw");
        do_write(16'h4E3B, 8'hA5, 1, "R2 border");
        do_write(16'h7E3B, 8'h1C, 1, "R2 pgc");
        do_write(16'h6E3A, 8'h55, 1, "R1 miss bit0");
        do_write(16'h4F3B, 8'h99, 1, "R1 miss bit8");
        do_write(16'h2E3B, 8'h77, 1, "R5 unassigned write");
        do_write(16'hBE3B, 8'h2D, 3, "R4 idx R8 held");
        do_write(16'hFE3B, 8'hC1, 2, "R4 rgb");
        do_write(16'hFE3B, 8'hC2, 1, "R8 second commit");
        do_read(16'h4E3B, 1'b1, "R6 border read");
        do_read(16'h4E3B, 1'b0, "R6 no iorq");
        do_read(16'hBE3B, 1'b1, "R7 idx read");
        do_read(16'hFE3B, 1'b1, "R7 rgb read");
        do_read(16'hCE3B, 1'b1, "R5 unassigned read");
        do_read(16'h0E3F, 1'b1, "R1 miss read");

        // Seeded random traffic
        for (int k = 0; k < 400; k++) begin
            logic [15:0] a;
            int mode = $urandom_range(0, 3);
            a = {4'($urandom_range(0, 15)), 12'hE3B};
            if (mode == 1) a[$urandom_range(0, 11)] ^= 1'b1;
            if (mode == 2) a = 16'($urandom);
            if ($urandom_range(0, 1) == 1)
                do_write(a, 8'($urandom), $urandom_range(1, 3), "R2 R4 rand write");
            else
                do_read(a, $urandom_range(0, 4) != 0, "R6 rand read");
        end

        // Reset in the middle of use
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        model[4] = 8'h07;
        check_outs("R3 re-reset");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule